// File: doc/BRIEF.md
# Indirect-Select Vectored Interrupt Controller

This block gathers up to 128 interrupt sources and drives one interrupt request line to a processor. It is programmed over a simple 32-bit register bus with separate read and write strobes. Software does not touch wide per-bit mask words. It first writes a source index into a select register. Command and configuration registers then act on that one source: its mode (priority and trigger kind), its vector word, and its enable, disable, clear and set commands.

Each source is pending either while its input is at the active level or after a latched edge. A software set command also makes it pending. Among the enabled pending sources, the one with the highest priority wins, and the lowest index wins a tie. An acknowledge read returns the winner's vector and pushes its priority onto an eight-level nesting stack. After that, only a strictly higher priority can raise the request line. Each end-of-interrupt write pops one level. When nothing is eligible, the acknowledge read returns a programmable spurious vector instead.

Top module: `isel_intc`

## Requirements
- R1: After reset, every source is disabled, its latch is clear, its mode reads 0x20 (priority 0, level-high), the nesting stack is empty and `irq_o` is low. A read of CORE (0x34) returns 0.
- R2: A write to SEL (0x00) takes the source index from bits [6:0], and SEL reads back that index. EN (0x40), DIS (0x44), CLR (0x48) and SET (0x4C) act on the selected source only, and only when wdata bit 0 is 1. With bit 0 at 0 the write has no effect.
- R3: MODE (0x04) of the selected source holds the priority in bits [2:0] and the trigger kind in bits [6:5]: 00 level-low, 01 level-high, 10 falling edge, 11 rising edge. A read returns these fields with all other bits zero.
- R4: VEC (0x08) reads and writes a 32-bit vector word for the selected source.
- R5: A level source is pending while its input is at the active level. An edge source latches pending on its edge. SET latches pending on any source and CLR clears that latch. If an edge or SET arrives in the same cycle as a clear, the source stays pending.
- R6: The winner is the enabled pending source with the highest priority. Among equal priorities the lowest index wins.
- R7: `irq_o` is registered. In each cycle it shows whether, in the previous cycle, some enabled pending source had a priority strictly above the stack top, or the stack was empty with any enabled pending source.
- R8: A read of ACK (0x10) while a source is eligible returns that source's vector word. It also pushes the source's priority onto the stack, clears the source's latch and records its index in CUR (0x18).
- R9: A read of ACK with no eligible source returns the value last written to SPU (0x3C). CUR then reads 0, and the current stack top (0 if the stack is empty) is pushed again.
- R10: Each write to EOI (0x38) pops one stack level and is ignored when the stack is empty. A push onto a full stack (eight levels) is ignored, so eight EOI writes always empty the stack.
- R11: MASKST (0x30) bit 0 reads the enable of the selected source. CORE bit 0 reads `irq_o` and bits [11:8] read the stack depth.
- R12: Read data is valid on `bus_rdata_o` in the cycle after the cycle in which `bus_re_i` is high, and reads may be issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Interrupt source inputs, synchronous to clk_i |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 1 | Interrupt request line |

## Verification
The hardest state to reach from the ports is a partly or completely full nesting stack with pending sources of equal and lower priority queued behind its top. The stack must also stay balanced when pushes occur at full depth or pops occur on an empty stack. The bench fills the stack with a run of spurious acknowledges and checks that the depth saturates and then drains through exactly eight end-of-interrupt writes. It adds directed tie and level/edge cases, then a long seeded random mix of selects, mode changes, acknowledges, end-of-interrupt writes and source toggles on sixteen active sources. A reference model predicts the request line every cycle and the data of every read.

// File: rtl/isel_intc_pkg.sv
`timescale 1ns/1ps
package isel_intc_pkg;
  localparam int PRIO_W = 3;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_LVL_HI = 2'd1,
    TRIG_FALL   = 2'd2,
    TRIG_RISE   = 2'd3
  } trig_e;

  typedef enum logic {RD_MISC = 1'b0, RD_VEC = 1'b1} rdsrc_e;

  localparam logic [7:0] A_SEL    = 8'h00;
  localparam logic [7:0] A_MODE   = 8'h04;
  localparam logic [7:0] A_VEC    = 8'h08;
  localparam logic [7:0] A_ACK    = 8'h10;
  localparam logic [7:0] A_CUR    = 8'h18;
  localparam logic [7:0] A_MASKST = 8'h30;
  localparam logic [7:0] A_CORE   = 8'h34;
  localparam logic [7:0] A_EOI    = 8'h38;
  localparam logic [7:0] A_SPU    = 8'h3C;
  localparam logic [7:0] A_EN     = 8'h40;
  localparam logic [7:0] A_DIS    = 8'h44;
  localparam logic [7:0] A_CLR    = 8'h48;
  localparam logic [7:0] A_SET    = 8'h4C;
endpackage

// File: rtl/isel_intc_srcbank.sv
`timescale 1ns/1ps
module isel_intc_srcbank
  import isel_intc_pkg::*;
#(
  parameter int N  = 128,
  parameter int IW = $clog2(N)
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic [N-1:0]          src_i,
  input  logic [IW-1:0]         sel_i,
  input  logic                  mode_we_i,
  input  logic [PRIO_W-1:0]     prio_wd_i,
  input  logic [1:0]            trig_wd_i,
  input  logic                  en_cmd_i,
  input  logic                  dis_cmd_i,
  input  logic                  clr_cmd_i,
  input  logic                  set_cmd_i,
  input  logic                  ack_i,
  input  logic [IW-1:0]         ack_idx_i,
  output logic [N-1:0]          req_o,
  output logic [N*PRIO_W-1:0]   prio_o,
  output logic [7:0]            sel_mode_o,
  output logic                  sel_en_o
);
  logic [N-1:0]   en_v;
  logic [2*N-1:0] trig_v;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic              hit;
    logic [PRIO_W-1:0] prio_q;
    trig_e             trig_q;
    logic              en_q, lat_q, prev_q;
    logic              lvl_act, edge_hit;

    assign hit = (sel_i == IW'(g));

    always_comb begin
      lvl_act  = 1'b0;
      edge_hit = 1'b0;
      case (trig_q)
        TRIG_LVL_LO: lvl_act  = ~src_i[g];
        TRIG_LVL_HI: lvl_act  = src_i[g];
        TRIG_FALL:   edge_hit = prev_q & ~src_i[g];
        default:     edge_hit = ~prev_q & src_i[g];
      endcase
    end

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        prio_q <= '0;
        trig_q <= TRIG_LVL_HI;
        en_q   <= 1'b0;
        lat_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        prev_q <= src_i[g];
        if (mode_we_i && hit) begin
          prio_q <= prio_wd_i;
          trig_q <= trig_e'(trig_wd_i);
        end
        if (en_cmd_i && hit)       en_q <= 1'b1;
        else if (dis_cmd_i && hit) en_q <= 1'b0;
        if (edge_hit || (set_cmd_i && hit))
          lat_q <= 1'b1;
        else if ((clr_cmd_i && hit) || (ack_i && ack_idx_i == IW'(g)))
          lat_q <= 1'b0;
      end
    end

    assign req_o[g]                   = en_q & (lat_q | lvl_act);
    assign prio_o[g*PRIO_W +: PRIO_W] = prio_q;
    assign trig_v[g*2 +: 2]           = trig_q;
    assign en_v[g]                    = en_q;
  end

  assign sel_mode_o = {1'b0, trig_v[sel_i*2 +: 2], 2'b00, prio_o[sel_i*PRIO_W +: PRIO_W]};
  assign sel_en_o   = en_v[sel_i];
endmodule

// File: rtl/isel_intc_arb.sv
`timescale 1ns/1ps
module isel_intc_arb
  import isel_intc_pkg::*;
#(
  parameter int N  = 128,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]        req_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                valid_o,
  output logic [IW-1:0]       idx_o,
  output logic [PRIO_W-1:0]   prio_o
);
  // Scan from the top index down; ">=" lets a lower index take over a tie.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] >= prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/isel_intc_nest.sv
`timescale 1ns/1ps
module isel_intc_nest
  import isel_intc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] val_i,
  output logic [PRIO_W-1:0] top_o,
  output logic [CW-1:0]     depth_o,
  output logic              empty_o
);
  logic [PRIO_W-1:0] stk_r [DEPTH];
  logic [CW-1:0]     depth_r, dm1;
  logic              full;

  assign dm1     = depth_r - 1'b1;
  assign full    = (depth_r == CW'(DEPTH));
  assign empty_o = (depth_r == '0);
  assign depth_o = depth_r;
  assign top_o   = empty_o ? '0 : stk_r[dm1[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      depth_r <= '0;
    end else if (push_i && pop_i) begin
      if (empty_o) begin
        stk_r[0] <= val_i;
        depth_r  <= CW'(1);
      end else begin
        stk_r[dm1[AW-1:0]] <= val_i;
      end
    end else if (push_i && !full) begin
      stk_r[depth_r[AW-1:0]] <= val_i;
      depth_r <= depth_r + 1'b1;
    end else if (pop_i && !empty_o) begin
      depth_r <= dm1;
    end
  end
endmodule

// File: rtl/isel_intc_vram.sv
`timescale 1ns/1ps
module isel_intc_vram #(
  parameter int ENTRIES = 128,
  parameter int W       = 32,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    q_o <= mem[raddr_i];
  end
endmodule

// File: rtl/isel_intc.sv
`timescale 1ns/1ps
module isel_intc
  import isel_intc_pkg::*;
#(
  parameter int N_SRC      = 128,
  parameter int NEST_DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [N_SRC-1:0] src_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic [7:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             irq_o
);
  localparam int IW = $clog2(N_SRC);
  localparam int CW = $clog2(NEST_DEPTH + 1);

  logic [IW-1:0]         sel_r;
  logic [31:0]           spu_r, cur_r, misc_r;
  rdsrc_e                rd_src_r;
  logic                  irq_r;

  logic [N_SRC-1:0]        req;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [7:0]              sel_mode;
  logic                    sel_en;
  logic                    win_valid;
  logic [IW-1:0]           win_idx;
  logic [PRIO_W-1:0]       win_prio, nest_top;
  logic [CW-1:0]           nest_depth;
  logic                    nest_empty;
  logic                    eligible, ack, ack_hit, push, pop;
  logic [31:0]             ram_q;

  wire wr_cmd = bus_we_i & bus_wdata_i[0];

  assign ack      = bus_re_i && bus_addr_i == A_ACK;
  assign eligible = win_valid && (nest_empty || win_prio > nest_top);
  assign ack_hit  = ack && eligible;
  assign push     = ack;
  assign pop      = bus_we_i && bus_addr_i == A_EOI;

  isel_intc_srcbank #(.N(N_SRC), .IW(IW)) u_bank (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .src_i     (src_i),
    .sel_i     (sel_r),
    .mode_we_i (bus_we_i && bus_addr_i == A_MODE),
    .prio_wd_i (bus_wdata_i[PRIO_W-1:0]),
    .trig_wd_i (bus_wdata_i[6:5]),
    .en_cmd_i  (wr_cmd && bus_addr_i == A_EN),
    .dis_cmd_i (wr_cmd && bus_addr_i == A_DIS),
    .clr_cmd_i (wr_cmd && bus_addr_i == A_CLR),
    .set_cmd_i (wr_cmd && bus_addr_i == A_SET),
    .ack_i     (ack_hit),
    .ack_idx_i (win_idx),
    .req_o     (req),
    .prio_o    (prio_flat),
    .sel_mode_o(sel_mode),
    .sel_en_o  (sel_en)
  );

  isel_intc_arb #(.N(N_SRC), .IW(IW)) u_arb (
    .req_i  (req),
    .prio_i (prio_flat),
    .valid_o(win_valid),
    .idx_o  (win_idx),
    .prio_o (win_prio)
  );

  isel_intc_nest #(.DEPTH(NEST_DEPTH)) u_nest (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .push_i (push),
    .pop_i  (pop),
    .val_i  (ack_hit ? win_prio : nest_top),
    .top_o  (nest_top),
    .depth_o(nest_depth),
    .empty_o(nest_empty)
  );

  isel_intc_vram #(.ENTRIES(N_SRC), .W(32)) u_vram (
    .clk_i  (clk_i),
    .we_i   (bus_we_i && bus_addr_i == A_VEC),
    .waddr_i(sel_r),
    .wdata_i(bus_wdata_i),
    .raddr_i(ack ? win_idx : sel_r),
    .q_o    (ram_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_r    <= '0;
      spu_r    <= '0;
      cur_r    <= '0;
      irq_r    <= 1'b0;
      misc_r   <= '0;
      rd_src_r <= RD_MISC;
    end else begin
      irq_r <= eligible;
      if (bus_we_i && bus_addr_i == A_SEL) sel_r <= bus_wdata_i[IW-1:0];
      if (bus_we_i && bus_addr_i == A_SPU) spu_r <= bus_wdata_i;
      if (ack) cur_r <= ack_hit ? 32'(win_idx) : 32'd0;
      if (bus_re_i) begin
        rd_src_r <= (bus_addr_i == A_VEC || ack_hit) ? RD_VEC : RD_MISC;
        case (bus_addr_i)
          A_SEL:    misc_r <= 32'(sel_r);
          A_MODE:   misc_r <= 32'(sel_mode);
          A_ACK:    misc_r <= spu_r;
          A_CUR:    misc_r <= cur_r;
          A_MASKST: misc_r <= 32'(sel_en);
          A_CORE:   misc_r <= (32'(nest_depth) << 8) | 32'(irq_r);
          A_SPU:    misc_r <= spu_r;
          default:  misc_r <= '0;
        endcase
      end
    end
  end

  assign bus_rdata_o = (rd_src_r == RD_VEC) ? ram_q : misc_r;
  assign irq_o       = irq_r;
endmodule

// File: rtl/isel_intc_chk.sv
`timescale 1ns/1ps
module isel_intc_chk #(
  parameter int N     = 128,
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(N),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          irq_o,
  input logic [CW-1:0] depth_i,
  input logic          push_i,
  input logic          pop_i,
  input logic          win_valid_i,
  input logic [IW-1:0] win_idx_i,
  input logic [N-1:0]  req_i
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    $fell(rst_i) |-> !irq_o && depth_i == '0);

  p_winner_requests_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    win_valid_i |-> req_i[win_idx_i]);

  p_irq_has_source_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o && !$past(rst_i) |-> $past(win_valid_i));

  p_push_grows_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    push_i && !pop_i && depth_i < CW'(DEPTH) |=> depth_i == $past(depth_i) + 1'b1);

  p_pop_shrinks_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    pop_i && !push_i && depth_i != '0 |=> depth_i == $past(depth_i) - 1'b1);

  p_depth_bound_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    depth_i <= CW'(DEPTH));
endmodule

bind isel_intc isel_intc_chk #(.N(N_SRC), .DEPTH(NEST_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .irq_o      (irq_o),
  .depth_i    (nest_depth),
  .push_i     (push),
  .pop_i      (pop),
  .win_valid_i(win_valid),
  .win_idx_i  (win_idx),
  .req_i      (req)
);

// File: tb/isel_intc_tb_top.sv
`timescale 1ns/1ps
module isel_intc_tb_top;
  localparam int N = 128;
  localparam logic [7:0] SEL = 8'h00, MODE = 8'h04, VEC = 8'h08, ACK = 8'h10,
    CUR = 8'h18, MSK = 8'h30, CORE = 8'h34, EOI = 8'h38, SPU = 8'h3C,
    EN = 8'h40, DIS = 8'h44, CLR = 8'h48, SET = 8'h4C;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] src = '0;
  logic we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  isel_intc dut_i (
    .clk_i(clk), .rst_i(rst), .src_i(src), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // reference model state
  logic [2:0]  m_prio [N];
  logic [1:0]  m_trig [N];
  logic        m_en [N], m_lat [N], m_prev [N];
  logic [31:0] m_vec [N];
  logic [2:0]  m_stk [8];
  int          m_dep = 0;
  logic [6:0]  m_sel = '0;
  logic [31:0] m_spu = '0, m_cur = '0;
  logic        m_irq = 1'b0;

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      SEL: return "R2";
      MODE: return "R3";
      VEC: return "R4";
      ACK: return "R8/R9";
      CUR: return "R8/R9";
      MSK: return "R11";
      CORE: return "R11";
      default: return "R12";
    endcase
  endfunction

  // one clock of the reference model, from the state before the edge
  task automatic step(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, output logic [31:0] er);
    bit found = 0; int bi = 0; int bp = 0; int top; bit elig;
    for (int i = 0; i < N; i++) begin
      bit lvl = (m_trig[i] == 2'd0 && !src[i]) || (m_trig[i] == 2'd1 && src[i]);
      if (m_en[i] && (m_lat[i] || lvl) && (!found || int'(m_prio[i]) > bp)) begin
        found = 1; bi = i; bp = int'(m_prio[i]);
      end
    end
    top  = (m_dep == 0) ? 0 : int'(m_stk[m_dep-1]);
    elig = found && (m_dep == 0 || bp > top);
    er = '0;
    if (r) case (a)
      SEL:  er = 32'(m_sel);
      MODE: er = {25'd0, m_trig[m_sel], 2'b00, m_prio[m_sel]};
      VEC:  er = m_vec[m_sel];
      ACK:  er = elig ? m_vec[bi] : m_spu;
      CUR:  er = m_cur;
      MSK:  er = 32'(m_en[m_sel]);
      CORE: er = (32'(m_dep) << 8) | 32'(m_irq);
      SPU:  er = m_spu;
      default: er = '0;
    endcase
    for (int i = 0; i < N; i++) begin
      bit edg = (m_trig[i] == 2'd2 && m_prev[i] && !src[i]) ||
                (m_trig[i] == 2'd3 && !m_prev[i] && src[i]);
      bit hit = (7'(i) == m_sel);
      if ((w && a == CLR && d[0] && hit) || (r && a == ACK && elig && bi == i)) m_lat[i] = 1'b0;
      if (edg || (w && a == SET && d[0] && hit)) m_lat[i] = 1'b1;
      m_prev[i] = src[i];
    end
    if (r && a == ACK) begin
      if (m_dep < 8) begin m_stk[m_dep] = elig ? 3'(bp) : 3'(top); m_dep++; end
      m_cur = elig ? 32'(bi) : 32'd0;
    end
    if (w) case (a)
      EOI:  if (m_dep > 0) m_dep--;
      SEL:  m_sel = d[6:0];
      MODE: begin m_prio[m_sel] = d[2:0]; m_trig[m_sel] = d[6:5]; end
      VEC:  m_vec[m_sel] = d;
      SPU:  m_spu = d;
      EN:   if (d[0]) m_en[m_sel] = 1'b1;
      DIS:  if (d[0]) m_en[m_sel] = 1'b0;
      default: ;
    endcase
    m_irq = elig;
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                     input logic [31:0] d, input string tag = "");
    logic [31:0] er;
    we = w; re = r; addr = a; wdata = d;
    step(w, r, a, d, er);
    @(negedge clk);
    chk(irq == m_irq, (tag != "") ? tag : "R7", 32'(irq), 32'(m_irq));
    if (r) chk(rdata == er, (tag != "") ? tag : tag_of(a), rdata, er);
    we = 1'b0; re = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string t = "");
    cyc(1'b1, 1'b0, a, d, t);
  endtask
  task automatic rd(input logic [7:0] a, input string t = "");
    cyc(1'b0, 1'b1, a, 32'd0, t);
  endtask
  task automatic idle();
    cyc(1'b0, 1'b0, 8'h00, 32'd0);
  endtask

  function automatic int pick();
    return ($urandom % 2) ? int'($urandom % 8) : 120 + int'($urandom % 8);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd31337));
    for (int i = 0; i < N; i++) begin
      m_prio[i] = '0; m_trig[i] = 2'd1; m_en[i] = 0; m_lat[i] = 0; m_prev[i] = 0; m_vec[i] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(CORE, "R1");
    rd(MODE, "R1");
    rd(MSK, "R1");

    // per-source vectors, as an initialisation pass would do
    for (int i = 0; i < N; i++) begin
      wr(SEL, 32'(i));
      wr(VEC, 32'h100 + 32'(i));
    end
    wr(SPU, 32'hDEAD_0000);
    wr(SEL, 32'd77); rd(VEC, "R4");
    wr(VEC, 32'hA5A5_5A5A); rd(VEC, "R4");
    wr(VEC, 32'h14D);

    // R3 mode fields
    wr(SEL, 32'h85); rd(SEL, "R2");
    wr(MODE, 32'hFF); rd(MODE, "R3");
    wr(MODE, 32'h20); rd(MODE, "R3");

    // R2 command bit 0 gates the command
    wr(EN, 32'hFFFF_FFFE); rd(MSK, "R2");
    wr(EN, 32'd1); rd(MSK, "R2");
    wr(DIS, 32'd1); rd(MSK, "R2");

    // R6 tie: sources 3 and 10, rising edge, priority 4
    wr(SEL, 32'd10); wr(MODE, 32'h64); wr(EN, 32'd1);
    wr(SEL, 32'd3);  wr(MODE, 32'h64); wr(EN, 32'd1);
    src[3] = 1'b1; src[10] = 1'b1; idle(); idle();
    rd(ACK, "R6"); rd(CUR, "R6");
    idle(); idle();              // equal priority is held off by the stack top
    wr(EOI, 32'd0); idle();
    rd(ACK, "R6"); rd(CUR, "R8"); wr(EOI, 32'd0);
    src[3] = 1'b0; src[10] = 1'b0; idle();

    // R5 level-low source, then SET and CLR on it
    wr(SEL, 32'd20); wr(MODE, 32'h02); wr(EN, 32'd1);
    idle(); rd(ACK, "R5"); wr(EOI, 32'd0);
    src[20] = 1'b1; idle();
    rd(ACK, "R9"); rd(CUR, "R9"); wr(EOI, 32'd0);
    wr(SET, 32'd1); idle(); rd(ACK, "R5"); wr(EOI, 32'd0);
    wr(SET, 32'd1); wr(CLR, 32'd1); rd(ACK, "R5"); wr(EOI, 32'd0);

    // R8 strictly higher priority nests over a lower one
    wr(SEL, 32'd3); wr(MODE, 32'h62); wr(SET, 32'd1);
    wr(SEL, 32'd10); wr(MODE, 32'h66);
    idle(); rd(ACK, "R8");
    wr(SET, 32'd1); idle(); rd(ACK, "R8"); rd(CORE, "R8");
    wr(EOI, 32'd0); wr(EOI, 32'd0); rd(CORE, "R10");

    // R10 saturate the stack with spurious acknowledges, then drain it
    wr(SEL, 32'd3); wr(DIS, 32'd1); wr(SEL, 32'd10); wr(DIS, 32'd1);
    wr(SEL, 32'd20); wr(DIS, 32'd1);
    for (int k = 0; k < 10; k++) rd(ACK, "R9");
    rd(CORE, "R10");
    for (int k = 0; k < 8; k++) wr(EOI, 32'd0);
    rd(CORE, "R10");
    wr(EOI, 32'd0); rd(CORE, "R10");

    // R12 back-to-back reads
    wr(SEL, 32'd77);
    rd(VEC, "R12"); rd(SEL, "R12"); rd(SPU, "R12"); rd(MODE, "R12");

    // seeded random mix on sources 0..7 and 120..127
    for (int n = 0; n < 6000; n++) begin
      if ($urandom % 3 == 0) src[pick()] = 1'($urandom);
      case ($urandom % 16)
        0, 1: wr(SEL, 32'(pick()));
        2:    wr(MODE, $urandom);
        3:    wr(VEC, $urandom);
        4, 5: wr(EN, 32'd1);
        6:    wr(DIS, 32'd1);
        7:    wr(CLR, 32'($urandom % 2));
        8:    wr(SET, 32'($urandom % 2));
        9, 10: rd(ACK);
        11, 12: wr(EOI, 32'd0);
        13:   rd(CORE);
        14:   rd(($urandom % 2) ? MSK : CUR);
        default: idle();
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule